// File: doc/BRIEF.md
# CAN Fault Confinement Unit

This block keeps the transmit and receive error counts of a CAN node and derives the node's fault-confinement state from them. The state is one of three: error active, error passive or bus off. The protocol engine drives single-cycle event strobes into the block: a transmit error, an acknowledge error, a good transmission, a receive error, a severe receive error and a good reception. It also supplies the sampled bus level, qualified by a once-per-bit strobe. The block returns both 8-bit counts, a 2-bit state code and a one-cycle pulse that marks entry into bus off.

Recovery from bus off works differently from normal counting. While the node is off the bus, a hidden run counter watches the bus for runs of 11 recessive bits. Each completed run adds one to the transmit count. When the transmit count reaches 128, the node rejoins as error active with both counts cleared.

The acknowledge-error and receive-count rules keep a node that is alone on the bus from ever reaching bus off. A maintenance port lets both counts be overwritten while freeze mode is asserted.

Top module: `can_fault_conf`

## Requirements
- R1: A synchronous active-low reset sets both counts to 0, clears the hidden run counter, sets the state code to 2'b00 and drops the interrupt.
- R2: Outside bus off, a transmit error, or an acknowledge error while error active, adds 8 to the transmit count. Otherwise a good transmission subtracts 1, stopping at 0. An error in the same cycle as a good transmission wins.
- R3: Outside bus off, with the receive count at 127 or below, the strobes act in this priority: a severe receive error adds 8, else a receive error adds 1, else a good reception subtracts 1, stopping at 0.
- R4: Outside bus off, the state code is 2'b01 (error passive) whenever either count is 128 or more.
- R5: Outside bus off, the state code is 2'b00 (error active) whenever both counts are 127 or below. A decrement that brings the last high count to 127 therefore restores error active.
- R6: When an increment would take the transmit count above 255, the state code becomes 2'b10 (bus off) and the transmit count becomes 0. The interrupt output is high for exactly the one cycle after that update.
- R7: While error passive, an acknowledge error leaves the transmit count unchanged.
- R8: With the receive count at 128 or more, receive errors of either kind leave it unchanged. A good reception loads it with 127.
- R9: In bus off, all six event strobes and all maintenance writes are ignored.
- R10: In bus off, each sampled bit with bus level 1 (recessive) advances the hidden run counter. Completing 11 in a row wraps the run counter and adds 1 to the transmit count. A sampled 0 (dominant) clears the run counter and leaves the transmit count unchanged.
- R11: When recovery brings the transmit count to 128, the state code becomes 2'b00 and both counts become 0.
- R12: A maintenance write loads a count only while freeze is high. It takes priority over that count's strobes in the same cycle, and the state follows the loaded value by the R4/R5 rules.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_err | input | 1 | Transmit error strobe |
| ack_err | input | 1 | Acknowledge error strobe |
| tx_ok | input | 1 | Good transmission strobe |
| rx_err | input | 1 | Receive error strobe |
| rx_severe | input | 1 | Severe receive error strobe |
| rx_ok | input | 1 | Good reception strobe |
| bit_tick | input | 1 | One pulse per sampled bus bit |
| bus_bit | input | 1 | Sampled bus level, 1 = recessive |
| frz_en | input | 1 | Freeze mode, enables maintenance writes |
| frz_wr_tx | input | 1 | Maintenance write of the transmit count |
| frz_wr_rx | input | 1 | Maintenance write of the receive count |
| frz_data | input | 8 | Maintenance write data |
| tx_cnt | output | 8 | Transmit error count |
| rx_cnt | output | 8 | Receive error count |
| fc_state | output | 2 | 00 error active, 01 error passive, 10 bus off |
| busoff_irq | output | 1 | One-cycle pulse on entry into bus off |

## Verification
The hardest situation to reach is the end of bus-off recovery. It needs 128 unbroken runs of 11 recessive bits, and the bench must also show that a dominant bit partway through a run costs only that run. A directed sequence drives a broken run first, then 127 complete runs, then a run one bit short, and finally the last bit. The bench checks the transmit count and the state at each stage. The random phase biases the bus toward recessive bits so that further bus-off entries and recoveries occur among the mixed strobes and freeze writes.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
   typedef enum logic [1:0] {
      FC_ACTIVE  = 2'b00,
      FC_PASSIVE = 2'b01,
      FC_BUSOFF  = 2'b10
   } fc_state_e;
endpackage

// File: rtl/can_fc_txcnt.sv
module can_fc_txcnt #(
   parameter int CNT_W      = 8,
   parameter int ERR_STEP   = 8,
   parameter int REC_TARGET = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             busoff,
   input  logic             passive,
   input  logic             tx_err,
   input  logic             ack_err,
   input  logic             tx_ok,
   input  logic             wr,
   input  logic [CNT_W-1:0] wdata,
   input  logic             rec_step,
   output logic [CNT_W-1:0] tx_q,
   output logic [CNT_W-1:0] tx_nxt,
   output logic             ovf,
   output logic             rec_done
);
   localparam int               SUM_W  = CNT_W + 1;
   localparam logic [SUM_W-1:0] STEP_V = SUM_W'(ERR_STEP);
   localparam logic [CNT_W-1:0] LAST_V = CNT_W'(REC_TARGET - 1);

   logic [SUM_W-1:0] sum;
   logic             err_hit;

   always_comb begin
      err_hit = tx_err | (ack_err & ~passive);
      sum     = {1'b0, tx_q};
      if (err_hit)
         sum = {1'b0, tx_q} + STEP_V;
      else if (tx_ok && tx_q != '0)
         sum = {1'b0, tx_q} - SUM_W'(1);
      ovf      = ~busoff & ~wr & sum[CNT_W];
      rec_done = busoff & rec_step & (tx_q == LAST_V);
      if (busoff) begin
         if (rec_done)
            tx_nxt = '0;
         else if (rec_step)
            tx_nxt = tx_q + CNT_W'(1);
         else
            tx_nxt = tx_q;
      end else if (wr) begin
         tx_nxt = wdata;
      end else if (sum[CNT_W]) begin
         tx_nxt = '0;
      end else begin
         tx_nxt = sum[CNT_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) tx_q <= '0;
      else        tx_q <= tx_nxt;
   end

   AST_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (passive && !busoff && ack_err && !tx_err && !wr) |=> (tx_q <= $past(tx_q))); // R7
   AST_DOMINANT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (busoff && !rec_step) |=> $stable(tx_q)); // R10
endmodule

// File: rtl/can_fc_rxcnt.sv
module can_fc_rxcnt #(
   parameter int CNT_W       = 8,
   parameter int SEVERE_STEP = 8,
   parameter int PASSIVE_AT  = 128,
   parameter int RX_RELOAD   = 127
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   input  logic             clr,
   input  logic             rx_err,
   input  logic             rx_severe,
   input  logic             rx_ok,
   input  logic             wr,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] rx_q,
   output logic [CNT_W-1:0] rx_nxt
);
   localparam logic [CNT_W-1:0] P_V   = CNT_W'(PASSIVE_AT);
   localparam logic [CNT_W-1:0] REL_V = CNT_W'(RX_RELOAD);
   localparam logic [CNT_W-1:0] SEV_V = CNT_W'(SEVERE_STEP);

   always_comb begin
      if (clr)
         rx_nxt = '0;
      else if (hold)
         rx_nxt = rx_q;
      else if (wr)
         rx_nxt = wdata;
      else if (rx_q >= P_V)
         rx_nxt = rx_ok ? REL_V : rx_q;
      else if (rx_severe)
         rx_nxt = rx_q + SEV_V;
      else if (rx_err)
         rx_nxt = rx_q + CNT_W'(1);
      else if (rx_ok && rx_q != '0)
         rx_nxt = rx_q - CNT_W'(1);
      else
         rx_nxt = rx_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rx_q <= '0;
      else        rx_q <= rx_nxt;
   end

   AST_RX_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_q >= P_V && !rx_ok && !wr && !clr) |=> $stable(rx_q)); // R8
   AST_RX_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_q >= P_V && rx_ok && !hold && !wr && !clr) |=> (rx_q == REL_V)); // R8
endmodule

// File: rtl/can_fc_recovery.sv
module can_fc_recovery #(
   parameter int RUN_BITS = 11
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic bit_tick,
   input  logic bus_bit,
   output logic step
);
   localparam int RW = (RUN_BITS > 1) ? $clog2(RUN_BITS) : 1;

   generate
      if (RUN_BITS == 1) begin : g_direct
         assign step = run & bit_tick & bus_bit;
      end else begin : g_count
         localparam logic [RW-1:0] LAST_V = RW'(RUN_BITS - 1);
         logic [RW-1:0] cnt_q;

         assign step = run & bit_tick & bus_bit & (cnt_q == LAST_V);

         always_ff @(posedge clk) begin
            if (!rst_n || !run)
               cnt_q <= '0;
            else if (bit_tick) begin
               if (!bus_bit || cnt_q == LAST_V)
                  cnt_q <= '0;
               else
                  cnt_q <= cnt_q + RW'(1);
            end
         end

         AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= LAST_V); // R10
         AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            !run |=> (cnt_q == '0)); // R1
         AST_DOMINANT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (run && bit_tick && !bus_bit) |=> (cnt_q == '0)); // R10
      end
   endgenerate
endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf
   import can_fc_pkg::*;
#(
   parameter int CNT_W         = 8,
   parameter int ERR_STEP      = 8,
   parameter int SEVERE_STEP   = 8,
   parameter int PASSIVE_AT    = 128,
   parameter int RX_RELOAD     = 127,
   parameter int RECESSIVE_RUN = 11,
   parameter int REC_TARGET    = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_err,
   input  logic             ack_err,
   input  logic             tx_ok,
   input  logic             rx_err,
   input  logic             rx_severe,
   input  logic             rx_ok,
   input  logic             bit_tick,
   input  logic             bus_bit,
   input  logic             frz_en,
   input  logic             frz_wr_tx,
   input  logic             frz_wr_rx,
   input  logic [CNT_W-1:0] frz_data,
   output logic [CNT_W-1:0] tx_cnt,
   output logic [CNT_W-1:0] rx_cnt,
   output logic [1:0]       fc_state,
   output logic             busoff_irq
);
   localparam logic [CNT_W-1:0] P_V = CNT_W'(PASSIVE_AT);

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("CNT_W too small");
      end
      if (PASSIVE_AT >= (1 << CNT_W) || RX_RELOAD >= PASSIVE_AT) begin : g_bad_thresh
         $error("threshold or reload out of range");
      end
      if (PASSIVE_AT - 1 + SEVERE_STEP >= (1 << CNT_W)) begin : g_bad_severe
         $error("severe step can overflow receive count");
      end
      if (REC_TARGET < 1 || REC_TARGET >= (1 << CNT_W) || ERR_STEP < 1 || RECESSIVE_RUN < 1) begin : g_bad_rec
         $error("recovery or step parameters out of range");
      end
   endgenerate

   fc_state_e        st_q, st_d;
   logic             irq_q;
   logic             busoff, passive;
   logic             rec_step, rec_done, ovf;
   logic [CNT_W-1:0] tx_q, tx_nxt, rx_q, rx_nxt;

   assign busoff  = (st_q == FC_BUSOFF);
   assign passive = (st_q == FC_PASSIVE);

   can_fc_recovery #(.RUN_BITS(RECESSIVE_RUN)) u_rec (
      .clk(clk), .rst_n(rst_n), .run(busoff),
      .bit_tick(bit_tick), .bus_bit(bus_bit), .step(rec_step));

   can_fc_txcnt #(.CNT_W(CNT_W), .ERR_STEP(ERR_STEP), .REC_TARGET(REC_TARGET)) u_tx (
      .clk(clk), .rst_n(rst_n), .busoff(busoff), .passive(passive),
      .tx_err(tx_err), .ack_err(ack_err), .tx_ok(tx_ok),
      .wr(frz_en & frz_wr_tx), .wdata(frz_data), .rec_step(rec_step),
      .tx_q(tx_q), .tx_nxt(tx_nxt), .ovf(ovf), .rec_done(rec_done));

   can_fc_rxcnt #(.CNT_W(CNT_W), .SEVERE_STEP(SEVERE_STEP),
                  .PASSIVE_AT(PASSIVE_AT), .RX_RELOAD(RX_RELOAD)) u_rx (
      .clk(clk), .rst_n(rst_n), .hold(busoff), .clr(rec_done),
      .rx_err(rx_err), .rx_severe(rx_severe), .rx_ok(rx_ok),
      .wr(frz_en & frz_wr_rx), .wdata(frz_data),
      .rx_q(rx_q), .rx_nxt(rx_nxt));

   always_comb begin
      if (busoff)
         st_d = rec_done ? FC_ACTIVE : FC_BUSOFF;
      else if (ovf)
         st_d = FC_BUSOFF;
      else if (tx_nxt >= P_V || rx_nxt >= P_V)
         st_d = FC_PASSIVE;
      else
         st_d = FC_ACTIVE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= FC_ACTIVE;
         irq_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         irq_q <= ovf;
      end
   end

   assign tx_cnt     = tx_q;
   assign rx_cnt     = rx_q;
   assign fc_state   = st_q;
   assign busoff_irq = irq_q;

   AST_PASSIVE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (!busoff && (tx_q >= P_V || rx_q >= P_V)) |-> passive); // R4
   AST_ACTIVE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!busoff && tx_q < P_V && rx_q < P_V) |-> (st_q == FC_ACTIVE)); // R5
   AST_BUSOFF_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busoff) |-> (tx_q == '0 && irq_q)); // R6
   AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |=> !irq_q); // R6
   AST_RECOVER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busoff) |-> (tx_q == '0 && rx_q == '0 && st_q == FC_ACTIVE)); // R11
endmodule

// File: tb/tb_can_fault_conf.sv
module tb_can_fault_conf;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_err = 0, ack_err = 0, tx_ok = 0, rx_err = 0, rx_severe = 0, rx_ok = 0;
   logic       bit_tick = 0, bus_bit = 1;
   logic       frz_en = 0, frz_wr_tx = 0, frz_wr_rx = 0;
   logic [7:0] frz_data = 0;
   logic [7:0] tx_cnt, rx_cnt;
   logic [1:0] fc_state;
   logic       busoff_irq;

   int n_chk = 0, n_fail = 0;
   int m_tx = 0, m_rx = 0, m_st = 0, m_rc = 0, m_irq = 0;

   always #10 clk = ~clk;

   can_fault_conf dut (
      .clk(clk), .rst_n(rst_n), .tx_err(tx_err), .ack_err(ack_err), .tx_ok(tx_ok),
      .rx_err(rx_err), .rx_severe(rx_severe), .rx_ok(rx_ok), .bit_tick(bit_tick),
      .bus_bit(bus_bit), .frz_en(frz_en), .frz_wr_tx(frz_wr_tx), .frz_wr_rx(frz_wr_rx),
      .frz_data(frz_data), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .fc_state(fc_state),
      .busoff_irq(busoff_irq));

   function automatic int st_from(int t, int r);
      return (t >= 128 || r >= 128) ? 1 : 0;
   endfunction

   task automatic model_step();
      int t;
      m_irq = 0;
      if (!rst_n) begin
         m_tx = 0; m_rx = 0; m_st = 0; m_rc = 0;
      end else if (m_st == 2) begin
         if (bit_tick) begin
            if (!bus_bit) m_rc = 0;
            else if (m_rc == 10) begin
               m_rc = 0; m_tx++;
               if (m_tx == 128) begin m_tx = 0; m_rx = 0; m_st = 0; end
            end else m_rc++;
         end
      end else begin
         m_rc = 0;
         if (frz_en && frz_wr_tx) t = frz_data;
         else if (tx_err || (ack_err && m_st == 0)) t = m_tx + 8;
         else if (tx_ok) t = (m_tx > 0) ? m_tx - 1 : 0;
         else t = m_tx;
         if (frz_en && frz_wr_rx) m_rx = frz_data;
         else if (m_rx >= 128) begin if (rx_ok) m_rx = 127; end
         else if (rx_severe) m_rx += 8;
         else if (rx_err) m_rx += 1;
         else if (rx_ok && m_rx > 0) m_rx -= 1;
         if (t > 255) begin m_tx = 0; m_st = 2; m_irq = 1; end
         else begin m_tx = t; m_st = st_from(m_tx, m_rx); end
      end
   endtask

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_in();
      tx_err = 0; ack_err = 0; tx_ok = 0; rx_err = 0; rx_severe = 0; rx_ok = 0;
      bit_tick = 0; bus_bit = 1; frz_en = 0; frz_wr_tx = 0; frz_wr_rx = 0; frz_data = 0;
   endtask

   task automatic cyc();
      @(posedge clk);
      model_step();
      @(negedge clk);
      clear_in();
   endtask

   task automatic send_bits(int n, logic lvl);
      for (int i = 0; i < n; i++) begin
         bit_tick = 1; bus_bit = lvl;
         cyc();
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired before completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      @(negedge clk);
      repeat (3) cyc();
      rst_n = 1;
      chk("R1 tx", tx_cnt, 0); chk("R1 rx", rx_cnt, 0);
      chk("R1 state", fc_state, 0); chk("R1 irq", busoff_irq, 0);

      tx_err = 1; cyc(); chk("R2 tx_err +8", tx_cnt, 8);
      tx_ok = 1; cyc(); chk("R2 tx_ok -1", tx_cnt, 7);
      tx_err = 1; tx_ok = 1; cyc(); chk("R2 error beats success", tx_cnt, 15);

      rx_err = 1; cyc(); chk("R3 rx_err +1", rx_cnt, 1);
      rx_severe = 1; cyc(); chk("R3 severe +8", rx_cnt, 9);
      rx_severe = 1; rx_err = 1; cyc(); chk("R3 severe priority", rx_cnt, 17);
      rx_ok = 1; cyc(); chk("R3 rx_ok -1", rx_cnt, 16);

      frz_wr_tx = 1; frz_data = 200; cyc(); chk("R12 write without freeze", tx_cnt, 15);
      frz_en = 1; frz_wr_tx = 1; frz_data = 124; tx_err = 1; cyc();
      chk("R12 write beats strobe", tx_cnt, 124); chk("R12 state", fc_state, 0);

      tx_err = 1; cyc(); chk("R4 tx 132", tx_cnt, 132); chk("R4 passive", fc_state, 1);
      ack_err = 1; cyc(); chk("R7 ack ignored", tx_cnt, 132);
      for (int i = 0; i < 4; i++) begin tx_ok = 1; cyc(); end
      chk("R4 at 128 still passive", fc_state, 1);
      tx_ok = 1; cyc(); chk("R5 tx 127", tx_cnt, 127); chk("R5 active", fc_state, 0);

      frz_en = 1; frz_wr_rx = 1; frz_data = 125; cyc(); chk("R12 rx write", rx_cnt, 125);
      rx_severe = 1; cyc(); chk("R4 rx 133", rx_cnt, 133); chk("R4 rx passive", fc_state, 1);
      rx_err = 1; cyc(); chk("R8 rx_err capped", rx_cnt, 133);
      rx_severe = 1; cyc(); chk("R8 severe capped", rx_cnt, 133);
      rx_ok = 1; cyc(); chk("R8 reload 127", rx_cnt, 127); chk("R5 back active", fc_state, 0);

      frz_en = 1; frz_wr_tx = 1; frz_data = 250; cyc(); chk("R12 passive by write", fc_state, 1);
      tx_err = 1; cyc();
      chk("R6 bus off", fc_state, 2); chk("R6 tx cleared", tx_cnt, 0); chk("R6 irq", busoff_irq, 1);
      cyc(); chk("R6 irq one cycle", busoff_irq, 0);

      tx_err = 1; ack_err = 1; tx_ok = 1; rx_err = 1; rx_severe = 1; rx_ok = 1;
      frz_en = 1; frz_wr_tx = 1; frz_wr_rx = 1; frz_data = 5; cyc();
      chk("R9 tx held", tx_cnt, 0); chk("R9 rx held", rx_cnt, 127); chk("R9 state", fc_state, 2);

      send_bits(10, 1); chk("R10 ten bits", tx_cnt, 0);
      send_bits(1, 0); send_bits(10, 1); chk("R10 dominant restarts run", tx_cnt, 0);
      send_bits(1, 1); chk("R10 run complete", tx_cnt, 1);
      for (int g = 0; g < 126; g++) send_bits(11, 1);
      chk("R10 tx 127", tx_cnt, 127);
      send_bits(10, 1); chk("R11 not yet", fc_state, 2);
      send_bits(1, 1);
      chk("R11 active", fc_state, 0); chk("R11 tx 0", tx_cnt, 0); chk("R11 rx 0", rx_cnt, 0);

      for (int k = 0; k < 6000; k++) begin
         tx_err    = ($urandom % 8) == 0;
         ack_err   = ($urandom % 8) == 0;
         tx_ok     = ($urandom % 4) == 0;
         rx_err    = ($urandom % 8) == 0;
         rx_severe = ($urandom % 16) == 0;
         rx_ok     = ($urandom % 3) == 0;
         bit_tick  = ($urandom % 2) == 0;
         bus_bit   = ($urandom % 16) != 0;
         frz_en    = ($urandom % 32) == 0;
         frz_wr_tx = ($urandom % 2) == 0;
         frz_wr_rx = ($urandom % 2) == 0;
         frz_data  = 8'($urandom);
         cyc();
         chk("R2 random tx", tx_cnt, m_tx);
         chk("R3 random rx", rx_cnt, m_rx);
         chk("R4 random state", fc_state, m_st);
         chk("R6 random irq", busoff_irq, m_irq);
      end

      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule